// File: doc/BRIEF.md
# Branch and Next-PC Sequencer

This block holds the program counter of a small microsequencer and works out the address of the next instruction. Each cycle in which `step` is high, one instruction issues at address `pc`. The decoder presents that instruction's operation code, its source register value, its bit/immediate field, its signed relative offset and its absolute target. From these, the block chooses the next address.

Every control transfer except the secure-mode switch has exactly one delay slot. The taken decision and its target are stored in a register. The instruction at `pc+1` then always issues, and the redirect takes effect on the step after it. Calls save a return address in a small return-address stack of parameterised depth. A plain return and an interrupt return both pop that stack. A push to a full stack or a pop from an empty one raises a one-cycle error pulse, and the instruction then behaves as a plain instruction. The secure-mode switch does not use the delay slot. When it is granted, it latches the requested mode and continues at `pc+3`.

Operation encodings on `op`: 0 none, 1 branch-if-equal-immediate, 2 branch-if-not-equal-immediate, 3 branch-if-bit-condition, 4 branch-unless-bit-condition, 5 call, 6 return, 7 secure switch.

Top module: `nbr_seq`

## Requirements
- R1: After reset, `pc` is 0, `slot_pending` is 0, `ras_level` is 0, and `stack_err`, `int_exit` and `secure_mode` are all 0.
- R2: While `step` is low, `pc`, `slot_pending` and `ras_level` hold their values.
- R3: An issued instruction with op 0, or a branch that is not taken, advances `pc` by 1 modulo 2^AW.
- R4: Op 1 is taken when `src_val` equals `fld` zero-extended to DW bits, and op 2 is taken when they differ. The target is `pc` plus `rel_off` read as a signed two's-complement number, modulo 2^AW.
- R5: The bit condition of ops 3 and 4 works as follows. With `fld`=0, the condition is "`src_val` is all zero". With `fld`=k>0, the condition is "bit k-1 of `src_val` is clear", and bit positions at DW or above count as clear. Op 3 is taken when the condition holds and op 4 when it does not, so op 3 with a zero source is always taken. Targets follow the rule in R4.
- R6: For a taken branch, call or return, `pc` becomes the issuing address plus 1 and `slot_pending` becomes 1. The next issued instruction moves `pc` to the stored target and clears `slot_pending`.
- R7: A branch, call, return or secure switch that issues in the delay slot (`slot_pending`=1) has no effect: there is no redirect, no stack change and no mode change.
- R8: A call (op 5) to a stack that is not full targets `abs_tgt` and pushes the issuing address plus 2.
- R9: A return (op 6) from a non-empty stack targets the most recently pushed address and pops it. When `ret_int` is 1, `int_exit` is 1 for the cycle after the return issues, and is 0 otherwise.
- R10: A call to a full stack or a return from an empty stack sets `stack_err` for one cycle, advances `pc` by 1, leaves `slot_pending` at 0 and leaves `ras_level` unchanged.
- R11: A secure switch (op 7) with `sec_grant`=1 sets `pc` to the issuing address plus 3, with no delay slot, and loads `secure_mode` from `src_val[0]`. With `sec_grant`=0 it advances `pc` by 1 and keeps `secure_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction issues at `pc` this cycle |
| op | input | 3 | Operation code of the issuing instruction |
| src_val | input | DW | Source register value (request bit 0 for op 7) |
| fld | input | FW | Bit index / immediate field |
| rel_off | input | OW | Signed relative branch offset |
| abs_tgt | input | AW | Absolute call target |
| ret_int | input | 1 | Selects interrupt return for op 6 |
| sec_grant | input | 1 | Secure switch is granted |
| pc | output | AW | Address of the instruction issuing now |
| slot_pending | output | 1 | A redirect waits behind the current delay slot |
| ras_level | output | LW | Number of stacked return addresses |
| stack_err | output | 1 | Stack overflow or underflow pulse |
| int_exit | output | 1 | Interrupt return pulse |
| secure_mode | output | 1 | Current secure mode |

## Verification
The bench sweeps every bit index from 0 up to beyond the register width against sources with isolated, full and zero bit patterns. A design that read field k as bit k, or that treated field 0 as bit 0, would turn the taken result around on the boundary bits. The delay slot is probed with a call placed inside it; a design that honoured that call would redirect twice or push a stray address onto the stack. Stack depth is driven past both ends, where a design that still redirected or changed the stack level would land on a garbage address. The secure switch is checked for a jump straight to three ahead, because a design that gave it a delay slot would run the instruction it was meant to skip.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_BEQI   = 3'd1,
    OP_BNEI   = 3'd2,
    OP_BEQB   = 3'd3,
    OP_BNEB   = 3'd4,
    OP_CALL   = 3'd5,
    OP_RET    = 3'd6,
    OP_SECURE = 3'd7
  } nbr_op_e;
endpackage

// File: rtl/nbr_cond.sv
module nbr_cond
  import nbr_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 6,
  parameter int AW = 8,
  parameter int OW = 8
) (
  input  nbr_op_e         op,
  input  logic [DW-1:0]   src_val,
  input  logic [FW-1:0]   fld,
  input  logic [AW-1:0]   pc,
  input  logic [OW-1:0]   rel_off,
  output logic            is_branch,
  output logic            taken,
  output logic [AW-1:0]   target
);
  // Field 0: whole source zero; field k: bit k-1 clear (out-of-range bits clear).
  function automatic logic bit_cond(input logic [DW-1:0] s, input logic [FW-1:0] f);
    logic hit;
    hit = 1'b0;
    if (f == '0) return (s == '0);
    for (int i = 0; i < DW; i++)
      if (f == FW'(i + 1)) hit = s[i];
    return !hit;
  endfunction

  function automatic logic imm_equal(input logic [DW-1:0] s, input logic [FW-1:0] f);
    return s == DW'(f);
  endfunction

  function automatic logic [AW-1:0] rel_target(input logic [AW-1:0] p, input logic [OW-1:0] o);
    return p + AW'($signed(o));
  endfunction

  always_comb begin
    is_branch = 1'b0;
    taken     = 1'b0;
    unique case (op)
      OP_BEQI: begin is_branch = 1'b1; taken =  imm_equal(src_val, fld); end
      OP_BNEI: begin is_branch = 1'b1; taken = !imm_equal(src_val, fld); end
      OP_BEQB: begin is_branch = 1'b1; taken =  bit_cond(src_val, fld);  end
      OP_BNEB: begin is_branch = 1'b1; taken = !bit_cond(src_val, fld);  end
      default: ;
    endcase
  end

  assign target = rel_target(pc, rel_off);
endmodule

// File: rtl/nbr_ras.sv
module nbr_ras #(
  parameter int AW    = 8,
  parameter int DEPTH = 2,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] slot_q [DEPTH];

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)                          slot_q[g] <= '0;
        else if (push && level == LW'(g))    slot_q[g] <= push_addr;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    level <= '0;
    else if (push) level <= level + LW'(1);
    else if (pop)  level <= level - LW'(1);
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (level == LW'(i + 1)) top = slot_q[i];
  end

  a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
endmodule

// File: rtl/nbr_seq.sv
module nbr_seq
  import nbr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int FW    = 6,
  parameter int AW    = 8,
  parameter int OW    = 8,
  parameter int DEPTH = 2,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [2:0]    op,
  input  logic [DW-1:0] src_val,
  input  logic [FW-1:0] fld,
  input  logic [OW-1:0] rel_off,
  input  logic [AW-1:0] abs_tgt,
  input  logic          ret_int,
  input  logic          sec_grant,
  output logic [AW-1:0] pc,
  output logic          slot_pending,
  output logic [LW-1:0] ras_level,
  output logic          stack_err,
  output logic          int_exit,
  output logic          secure_mode
);
  nbr_op_e       op_e;
  logic          br_is, br_take;
  logic [AW-1:0] br_target, ras_top, tgt_q;
  logic          ras_full, ras_empty;
  logic [AW-1:0] pc_nxt, tgt_nxt;
  logic          pend_nxt;

  // Named internal events
  logic ev_eval, ev_redirect, ev_branch, ev_push, ev_pop, ev_overflow;
  logic ev_underflow, ev_iret, ev_secure_ok;

  assign op_e = nbr_op_e'(op);

  nbr_cond #(.DW(DW), .FW(FW), .AW(AW), .OW(OW)) cond_i (
    .op(op_e), .src_val(src_val), .fld(fld), .pc(pc), .rel_off(rel_off),
    .is_branch(br_is), .taken(br_take), .target(br_target)
  );

  assign ev_eval      = step && !slot_pending;
  assign ev_redirect  = step && slot_pending;
  assign ev_branch    = ev_eval && br_is && br_take;
  assign ev_push      = ev_eval && (op_e == OP_CALL) && !ras_full;
  assign ev_overflow  = ev_eval && (op_e == OP_CALL) && ras_full;
  assign ev_pop       = ev_eval && (op_e == OP_RET) && !ras_empty;
  assign ev_underflow = ev_eval && (op_e == OP_RET) && ras_empty;
  assign ev_iret      = ev_pop && ret_int;
  assign ev_secure_ok = ev_eval && (op_e == OP_SECURE) && sec_grant;

  nbr_ras #(.AW(AW), .DEPTH(DEPTH)) ras_i (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .pop(ev_pop),
    .push_addr(pc + AW'(2)), .top(ras_top), .level(ras_level),
    .full(ras_full), .empty(ras_empty)
  );

  always_comb begin
    pc_nxt   = pc + AW'(1);
    pend_nxt = 1'b0;
    tgt_nxt  = tgt_q;
    if (slot_pending) begin
      pc_nxt = tgt_q;
    end else if (ev_secure_ok) begin
      pc_nxt = pc + AW'(3);
    end else if (ev_branch) begin
      pend_nxt = 1'b1;
      tgt_nxt  = br_target;
    end else if (ev_push) begin
      pend_nxt = 1'b1;
      tgt_nxt  = abs_tgt;
    end else if (ev_pop) begin
      pend_nxt = 1'b1;
      tgt_nxt  = ras_top;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc           <= '0;
      slot_pending <= 1'b0;
      tgt_q        <= '0;
      stack_err    <= 1'b0;
      int_exit     <= 1'b0;
      secure_mode  <= 1'b0;
    end else begin
      stack_err <= ev_overflow || ev_underflow;
      int_exit  <= ev_iret;
      if (step) begin
        pc           <= pc_nxt;
        slot_pending <= pend_nxt;
        tgt_q        <= tgt_nxt;
      end
      if (ev_secure_ok) secure_mode <= src_val[0];
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc) && $stable(ras_level));
  a_r6_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    ev_redirect |=> (pc == $past(tgt_q)) && !slot_pending);
  a_r6_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_branch || ev_push || ev_pop) |=> (pc == $past(pc) + AW'(1)) && slot_pending);
  a_r7_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_redirect |=> $stable(ras_level) && $stable(secure_mode));
  a_r9_iret_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev_iret |=> int_exit);
  a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_overflow || ev_underflow) |=> stack_err && !slot_pending
      && (pc == $past(pc) + AW'(1)) && $stable(ras_level));
  a_r11_secure_skip: assert property (@(posedge clk) disable iff (!rst_n)
    ev_secure_ok |=> (pc == $past(pc) + AW'(3)) && !slot_pending);
endmodule

// File: tb/nbr_seq_tb.sv
module nbr_seq_tb_top;
  localparam int DW = 16, FW = 6, AW = 8, OW = 8, DEPTH = 2;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, step = 1'b0;
  logic [2:0] op = '0;
  logic [DW-1:0] src_val = '0;
  logic [FW-1:0] fld = '0;
  logic [OW-1:0] rel_off = '0;
  logic [AW-1:0] abs_tgt = '0;
  logic ret_int = 1'b0, sec_grant = 1'b0;
  logic [AW-1:0] pc;
  logic slot_pending, stack_err, int_exit, secure_mode;
  logic [LW-1:0] ras_level;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nbr_seq #(.DW(DW), .FW(FW), .AW(AW), .OW(OW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .step(step), .op(op), .src_val(src_val),
    .fld(fld), .rel_off(rel_off), .abs_tgt(abs_tgt), .ret_int(ret_int),
    .sec_grant(sec_grant), .pc(pc), .slot_pending(slot_pending),
    .ras_level(ras_level), .stack_err(stack_err), .int_exit(int_exit),
    .secure_mode(secure_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; step = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic issue(input int o, input int s, input int f, input int off,
                       input int tgt, input bit ri, input bit gr);
    op = 3'(o); src_val = DW'(s); fld = FW'(f); rel_off = OW'(off);
    abs_tgt = AW'(tgt); ret_int = ri; sec_grant = gr; step = 1'b1;
    @(negedge clk);
    step = 1'b0; op = '0;
  endtask

  task automatic idle();
    step = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit model_bit(input int s, input int k);
    if (k == 0) return (s & 16'hFFFF) == 0;
    if (k > DW) return 1'b1;
    return ((s >> (k - 1)) & 1) == 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int srcs[5] = '{0, 1, 16'h8000, 16'h00F0, 16'hFFFF};
    do_reset();
    // R1 reset state
    chk("R1 pc", pc, 0); chk("R1 pend", slot_pending, 0); chk("R1 level", ras_level, 0);
    chk("R1 err", stack_err, 0); chk("R1 iexit", int_exit, 0); chk("R1 sec", secure_mode, 0);

    // R2 / R3
    idle(); chk("R2 pc idle", pc, 0);
    issue(0, 0, 0, 0, 0, 0, 0); chk("R3 pc+1", pc, 1);
    idle(); chk("R2 pc hold", pc, 1);

    // R4 immediate compare sweep, negative offset wraps
    foreach (srcs[i]) begin
      for (int f = 0; f < 64; f += 7) begin
        for (int o = 1; o <= 2; o++) begin
          bit tk;
          tk = (srcs[i] == f) ^ (o == 2);
          do_reset();
          issue(o, srcs[i], f, 8'hF0, 0, 0, 0);
          chk("R4 slot pc", pc, 1); chk("R4 pend", slot_pending, tk);
          issue(0, 0, 0, 0, 0, 0, 0);
          chk("R4 dest", pc, tk ? 240 : 2);
        end
      end
    end
    do_reset(); issue(1, 9, 9, 0, 0, 0, 0); issue(0, 0, 0, 0, 0, 0, 0);
    chk("R4 equal taken off0", pc, 0);

    // R5 bit-test sweep over all indices incl. out of range
    foreach (srcs[i]) begin
      for (int k = 0; k <= 20; k++) begin
        for (int o = 3; o <= 4; o++) begin
          bit tk;
          tk = model_bit(srcs[i], k) ^ (o == 4);
          do_reset();
          issue(o, srcs[i], k, 37, 0, 0, 0);
          chk("R5 pend", slot_pending, tk);
          issue(0, 0, 0, 0, 0, 0, 0);
          chk("R5 dest", pc, tk ? 37 : 2);
        end
      end
    end

    // R6 / R7: idle inside slot, then a call in the slot is ignored
    do_reset();
    issue(3, 0, 5, 10, 0, 0, 0);
    chk("R6 slot pc", pc, 1); chk("R6 pend", slot_pending, 1);
    idle(); chk("R6 hold in slot", pc, 1);
    issue(5, 0, 0, 0, 50, 0, 0);
    chk("R7 redirect wins", pc, 10); chk("R7 no push", ras_level, 0);
    chk("R7 pend clear", slot_pending, 0);
    issue(0, 0, 0, 0, 0, 0, 0); chk("R7 no second redirect", pc, 11);
    issue(3, 0, 0, 4, 0, 0, 0);
    issue(7, 1, 0, 0, 0, 0, 1);
    chk("R7 secure in slot ignored", secure_mode, 0); chk("R7 slot dest", pc, 15);

    // R8 / R9 call and return
    do_reset();
    issue(0, 0, 0, 0, 0, 0, 0); issue(0, 0, 0, 0, 0, 0, 0); issue(0, 0, 0, 0, 0, 0, 0);
    issue(5, 0, 0, 0, 100, 0, 0);
    chk("R8 call slot", pc, 4); chk("R8 level", ras_level, 1);
    issue(0, 0, 0, 0, 0, 0, 0); chk("R8 abs dest", pc, 100);
    issue(6, 0, 0, 0, 0, 0, 0); chk("R9 ret slot", pc, 101); chk("R9 iexit plain", int_exit, 0);
    issue(0, 0, 0, 0, 0, 0, 0); chk("R9 ret dest", pc, 5); chk("R9 level", ras_level, 0);

    // R10 overflow, R9 iret, R10 underflow
    do_reset();
    issue(5, 0, 0, 0, 20, 0, 0); issue(0, 0, 0, 0, 0, 0, 0);
    issue(5, 0, 0, 0, 40, 0, 0); issue(0, 0, 0, 0, 0, 0, 0);
    chk("R8 nested dest", pc, 40); chk("R8 level2", ras_level, 2);
    issue(5, 0, 0, 0, 60, 0, 0);
    chk("R10 ovf err", stack_err, 1); chk("R10 ovf pc", pc, 41);
    chk("R10 ovf pend", slot_pending, 0); chk("R10 ovf level", ras_level, 2);
    issue(0, 0, 0, 0, 0, 0, 0);
    chk("R10 err pulse", stack_err, 0); chk("R10 no redirect", pc, 42);
    issue(6, 0, 0, 0, 0, 1, 0); chk("R9 iexit", int_exit, 1);
    issue(0, 0, 0, 0, 0, 0, 0); chk("R9 iexit pulse", int_exit, 0); chk("R9 iret dest", pc, 22);
    issue(6, 0, 0, 0, 0, 0, 0); issue(0, 0, 0, 0, 0, 0, 0);
    chk("R9 outer dest", pc, 2); chk("R9 empty", ras_level, 0);
    issue(6, 0, 0, 0, 0, 1, 0);
    chk("R10 udf err", stack_err, 1); chk("R10 udf pc", pc, 3);
    chk("R10 udf iexit", int_exit, 0); chk("R10 udf pend", slot_pending, 0);

    // R11 secure switch
    do_reset();
    issue(0, 0, 0, 0, 0, 0, 0);
    issue(7, 1, 0, 0, 0, 0, 1);
    chk("R11 skip", pc, 4); chk("R11 mode set", secure_mode, 1); chk("R11 pend", slot_pending, 0);
    issue(7, 0, 0, 0, 0, 0, 0);
    chk("R11 denied pc", pc, 5); chk("R11 denied mode", secure_mode, 1);
    issue(7, 0, 0, 0, 0, 0, 1);
    chk("R11 clear pc", pc, 8); chk("R11 mode clear", secure_mode, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule